// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Sequencer

This block sits beside the access controller of an asynchronous DRAM with 1K refresh. After reset it measures a start-up pause. It then runs a fixed burst of warm-up refresh cycles. Only after that does it raise a ready flag that lets normal reads and writes begin. From then on an interval timer asks for one refresh per slot, paced so that all rows are covered within the retention period.

The block asks for the memory bus with a request line. It waits for a grant and then drives the row strobe, the column strobes and the write-enable line itself for one full refresh cycle. It holds an ownership flag high while it does so.

A parameter picks one of two refresh styles:
- **Column-first:** all column strobes drop ahead of the row strobe, with write-enable held high. No address is needed.
- **Row-only:** the column strobes stay high while the row strobe pulses. An internal row counter supplies the address and advances after each cycle.

Refresh slots that the controller has not yet granted are stored, up to a small limit. They are then issued back to back once the grant returns.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, `rfsh_req` stays low for exactly `PAUSE_CYC` clock edges and rises after edge `PAUSE_CYC`.
- R2: `ready` stays low until exactly `INIT_CYCLES` refresh cycles have completed after the pause. It rises at the end of the last of them and then stays high until reset.
- R3: Once ready, with the grant held high, row-strobe falls are exactly `INTERVAL_CYC` cycles apart. The window of `ROWS*INTERVAL_CYC` cycles that follows ready, plus the cycle lead-in, holds exactly `ROWS` refresh cycles.
- R4: In column-first style, every column strobe is low on the cycle the row strobe falls, having fallen exactly `T_LEAD` cycles earlier. The column strobes rise again exactly `T_CHR` cycles after the row strobe falls.
- R5: `mem_we_n` is high at every row-strobe fall of a column-first cycle.
- R6: The row strobe stays low for exactly `T_RAS` cycles per refresh. Between its rise and the next column-strobe fall there are at least `T_RP` cycles. Between its rise and its next fall there are at least `T_RP+T_LEAD` cycles.
- R7: In row-only style, all column strobes are high at each row-strobe fall. `row_addr` equals the number of refresh cycles completed since reset, modulo 2^ROW_W, and wraps from 1023 to 0.
- R8: While `rfsh_gnt` is low, no refresh cycle starts, `bus_own` stays low and `rfsh_req` stays high while work is owed.
- R9: Interval slots that are not granted are counted, saturating at `PEND_MAX`. When the grant returns, `min(missed slots, PEND_MAX)` cycles run back to back.
- R10: While reset is high, `rfsh_req`, `bus_own` and `ready` are low, all strobes and `mem_we_n` are high, and `row_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_gnt | input | 1 | Bus grant from the access controller |
| rfsh_req | output | 1 | Refresh bus request |
| bus_own | output | 1 | High while a refresh cycle drives the strobes |
| ready | output | 1 | Start-up sequence finished; normal access allowed |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | CAS_LINES | Column strobes, active low |
| mem_we_n | output | 1 | Write enable, active low (held high) |
| row_addr | output | ROW_W | Refresh row in row-only style, zero otherwise |

## Verification
A fault in the pause counter shows up as a request edge on the wrong clock count, visible within the pause itself. A miscounted warm-up burst shows up as the wrong number of strobe pulses at the rising edge of `ready`. An off-by-one in the phase counter shows up on the very next refresh as a wrong strobe lead, hold, pulse or precharge length. A broken pending counter or row counter shows up only across several cycles: as a wrong burst length once the grant returns, or as a row address that no longer matches the count of completed cycles.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HOLD,
        PH_ACTIVE,
        PH_PRE
    } rf_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic int unsigned width_for(input int unsigned v);
        int unsigned w;
        w = 1;
        while ((1 << w) <= v) w++;
        return w;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic strobe_t phase_strobes(input rf_phase_e ph, input logic column_first);
        strobe_t s;
        s.ras_n = 1'b1;
        s.cas_n = 1'b1;
        case (ph)
            PH_LEAD:   s.cas_n = !column_first;
            PH_HOLD: begin
                s.ras_n = 1'b0;
                s.cas_n = !column_first;
            end
            PH_ACTIVE: s.ras_n = 1'b0;
            default:   ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC    = 25000,
    parameter int unsigned INTERVAL_CYC = 1940
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic pause_done_o,
    output logic tick_o
);
    localparam int unsigned PW = width_for(PAUSE_CYC);
    localparam int unsigned IW = width_for(INTERVAL_CYC);

    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] ivl_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_cnt    <= '0;
            pause_done_o <= 1'b0;
        end else if (!pause_done_o) begin
            if (pause_cnt == PW'(PAUSE_CYC - 1)) pause_done_o <= 1'b1;
            else                                 pause_cnt    <= pause_cnt + 1'b1;
        end
    end

    assign tick_o = run_i && (ivl_cnt == IW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i)  ivl_cnt <= '0;
        else if (tick_o)    ivl_cnt <= '0;
        else                ivl_cnt <= ivl_cnt + 1'b1;
    end

    AST_PAUSE_STAYS: assert property (@(posedge clk) disable iff (rst)
        pause_done_o |=> pause_done_o); // R1
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick_o && INTERVAL_CYC > 1) |=> !tick_o); // R3
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned PEND_MAX    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pause_done_i,
    input  logic tick_i,
    input  logic done_i,
    output logic want_o,
    output logic ready_o
);
    localparam int unsigned NW = width_for(INIT_CYCLES);
    localparam int unsigned CW = width_for(PEND_MAX);

    logic [NW-1:0] init_left;
    logic [CW-1:0] pend;
    logic          init_busy;
    logic          pend_dec;

    assign init_busy = (init_left != '0);
    assign pend_dec  = done_i && !init_busy;
    assign ready_o   = pause_done_i && !init_busy;
    assign want_o    = pause_done_i && (init_busy || pend != '0);

    always_ff @(posedge clk) begin
        if (rst)                      init_left <= NW'(INIT_CYCLES);
        else if (done_i && init_busy) init_left <= init_left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (tick_i && !pend_dec) begin
            if (pend != CW'(PEND_MAX)) pend <= pend + 1'b1;
        end else if (pend_dec && !tick_i) begin
            pend <= pend - 1'b1;
        end
    end

    AST_PEND_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (pend == CW'(PEND_MAX) && tick_i && !pend_dec) |=> (pend == CW'(PEND_MAX))); // R9
    AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> ready_o); // R2
    AST_NO_CREDIT_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> (pend == '0)); // R2
endmodule

// File: rtl/rfsh_engine.sv
module rfsh_engine
    import dram_rfsh_pkg::*;
#(
    parameter bit          COLUMN_FIRST = 1'b1,
    parameter int unsigned CAS_LINES    = 4,
    parameter int unsigned ROW_W        = 10,
    parameter int unsigned T_LEAD       = 2,
    parameter int unsigned T_CHR        = 2,
    parameter int unsigned T_RAS        = 7,
    parameter int unsigned T_RP         = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 want_i,
    input  logic                 gnt_i,
    output logic                 req_o,
    output logic                 own_o,
    output logic                 done_o,
    output logic                 ras_n_o,
    output logic [CAS_LINES-1:0] cas_n_o,
    output logic                 we_n_o,
    output logic [ROW_W-1:0]     row_o
);
    localparam int unsigned DW = width_for(max4(T_LEAD, T_CHR, T_RAS, T_RP));

    rf_phase_e     ph;
    logic [DW-1:0] cnt;
    logic          start;
    logic          last;
    strobe_t       stb;

    assign req_o  = (ph == PH_IDLE) && want_i;
    assign start  = req_o && gnt_i;
    assign last   = (cnt == '0);
    assign done_o = (ph == PH_PRE) && last;
    assign own_o  = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph  <= PH_LEAD;
                    cnt <= DW'(T_LEAD - 1);
                end
                PH_LEAD: if (last) begin
                    ph  <= PH_HOLD;
                    cnt <= DW'(T_CHR - 1);
                end else cnt <= cnt - 1'b1;
                PH_HOLD: if (last) begin
                    ph  <= PH_ACTIVE;
                    cnt <= DW'(T_RAS - T_CHR - 1);
                end else cnt <= cnt - 1'b1;
                PH_ACTIVE: if (last) begin
                    ph  <= PH_PRE;
                    cnt <= DW'(T_RP - 1);
                end else cnt <= cnt - 1'b1;
                PH_PRE: if (last) ph <= PH_IDLE;
                        else      cnt <= cnt - 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign stb     = phase_strobes(ph, COLUMN_FIRST);
    assign ras_n_o = stb.ras_n;
    assign cas_n_o = {CAS_LINES{stb.cas_n}};
    assign we_n_o  = 1'b1;

    generate
        if (COLUMN_FIRST) begin : g_colfirst
            assign row_o = '0;

            AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
                $fell(ras_n_o) |-> (cas_n_o == '0)); // R4
            AST_CAS_RISES_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
                $rose(cas_n_o[0]) |-> !ras_n_o); // R4
        end else begin : g_rowonly
            logic [ROW_W-1:0] row_q;

            always_ff @(posedge clk) begin
                if (rst)         row_q <= '0;
                else if (done_o) row_q <= row_q + 1'b1;
            end
            assign row_o = row_q;

            AST_ROW_ADVANCES: assert property (@(posedge clk) disable iff (rst)
                done_o |=> (row_o == $past(row_o) + 1'b1)); // R7
            AST_ROW_STEADY_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
                (!ras_n_o && !$fell(ras_n_o)) |-> $stable(row_o)); // R7
        end
    endgenerate

    AST_WAIT_FOR_GNT: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && !gnt_i) |=> (ph == PH_IDLE)); // R8
    AST_RAS_AFTER_LEAD: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> ($past(ph) == PH_LEAD)); // R6
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter bit          COLUMN_FIRST = 1'b1,
    parameter int unsigned CAS_LINES    = 4,
    parameter int unsigned ROW_W        = 10,
    parameter int unsigned PAUSE_CYC    = 25000,
    parameter int unsigned INTERVAL_CYC = 1940,
    parameter int unsigned INIT_CYCLES  = 8,
    parameter int unsigned PEND_MAX     = 3,
    parameter int unsigned T_LEAD       = 2,
    parameter int unsigned T_CHR        = 2,
    parameter int unsigned T_RAS        = 7,
    parameter int unsigned T_RP         = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rfsh_gnt,
    output logic                 rfsh_req,
    output logic                 bus_own,
    output logic                 ready,
    output logic                 mem_ras_n,
    output logic [CAS_LINES-1:0] mem_cas_n,
    output logic                 mem_we_n,
    output logic [ROW_W-1:0]     row_addr
);
    logic pause_done;
    logic tick;
    logic want;
    logic done;

    rfsh_timer #(
        .PAUSE_CYC    (PAUSE_CYC),
        .INTERVAL_CYC (INTERVAL_CYC)
    ) timer_i (
        .clk          (clk),
        .rst          (rst),
        .run_i        (ready),
        .pause_done_o (pause_done),
        .tick_o       (tick)
    );

    rfsh_credit #(
        .INIT_CYCLES (INIT_CYCLES),
        .PEND_MAX    (PEND_MAX)
    ) credit_i (
        .clk          (clk),
        .rst          (rst),
        .pause_done_i (pause_done),
        .tick_i       (tick),
        .done_i       (done),
        .want_o       (want),
        .ready_o      (ready)
    );

    rfsh_engine #(
        .COLUMN_FIRST (COLUMN_FIRST),
        .CAS_LINES    (CAS_LINES),
        .ROW_W        (ROW_W),
        .T_LEAD       (T_LEAD),
        .T_CHR        (T_CHR),
        .T_RAS        (T_RAS),
        .T_RP         (T_RP)
    ) engine_i (
        .clk     (clk),
        .rst     (rst),
        .want_i  (want),
        .gnt_i   (rfsh_gnt),
        .req_o   (rfsh_req),
        .own_o   (bus_own),
        .done_o  (done),
        .ras_n_o (mem_ras_n),
        .cas_n_o (mem_cas_n),
        .we_n_o  (mem_we_n),
        .row_o   (row_addr)
    );
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
    localparam int unsigned CASL  = 4;
    localparam int unsigned RW    = 10;
    localparam int unsigned ROWS  = 1024;
    localparam int unsigned PAUSE = 100;
    localparam int unsigned IVL   = 80;
    localparam int unsigned INIT  = 8;
    localparam int unsigned PMAX  = 3;
    localparam int unsigned TL    = 2;
    localparam int unsigned TC    = 2;
    localparam int unsigned TR    = 7;
    localparam int unsigned TP    = 6;

    // withheld interval slots, expected back-to-back cycles after grant
    localparam int unsigned NVEC = 4;
    localparam int unsigned VEC [NVEC][2] = '{'{1, 1}, '{2, 2}, '{3, 3}, '{5, 3}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b1;
    always #4 clk = !clk;

    logic            req, own, rdy, ras_n, we_n;
    logic [CASL-1:0] cas_n;
    logic [RW-1:0]   row;
    logic            ro_req, ro_own, ro_rdy, ro_ras_n, ro_we_n;
    logic [CASL-1:0] ro_cas_n;
    logic [RW-1:0]   ro_row;

    dram_refresh_seq #(.COLUMN_FIRST(1'b1), .CAS_LINES(CASL), .ROW_W(RW), .PAUSE_CYC(PAUSE),
        .INTERVAL_CYC(IVL), .INIT_CYCLES(INIT), .PEND_MAX(PMAX), .T_LEAD(TL), .T_CHR(TC),
        .T_RAS(TR), .T_RP(TP)) dut_i (
        .clk(clk), .rst(rst), .rfsh_gnt(gnt), .rfsh_req(req), .bus_own(own), .ready(rdy),
        .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n), .row_addr(row));

    dram_refresh_seq #(.COLUMN_FIRST(1'b0), .CAS_LINES(CASL), .ROW_W(RW), .PAUSE_CYC(PAUSE),
        .INTERVAL_CYC(IVL), .INIT_CYCLES(INIT), .PEND_MAX(PMAX), .T_LEAD(TL), .T_CHR(TC),
        .T_RAS(TR), .T_RP(TP)) dut_ro_i (
        .clk(clk), .rst(rst), .rfsh_gnt(gnt), .rfsh_req(ro_req), .bus_own(ro_own), .ready(ro_rdy),
        .mem_ras_n(ro_ras_n), .mem_cas_n(ro_cas_n), .mem_we_n(ro_we_n), .row_addr(ro_row));

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // ---------------- monitor ----------------
    longint edges = 0;
    always @(posedge clk) edges <= rst ? 0 : edges + 1;

    longint n_fall = 0, t_cas_fall = -1, t_ras_fall = -1, t_ras_rise = -1;
    bit     p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0, p_rdy = 1'b0, p_ro_ras = 1'b1;
    bit     req_seen = 1'b0, last_fall_rdy = 1'b0, space_on = 1'b0, wrapped = 1'b0;
    longint exp_row = 0;

    always @(negedge clk) begin
        if (rst) begin
            n_fall = 0; t_cas_fall = -1; t_ras_fall = -1; t_ras_rise = -1;
            exp_row = 0; last_fall_rdy = 1'b0;
        end else begin
            if (!p_req && req && !req_seen) begin
                req_seen = 1'b1;
                chk(edges == PAUSE && !rdy, "R1 request after pause", edges, PAUSE);
            end
            if (p_cas && !cas_n[0]) begin
                t_cas_fall = edges;
                if (t_ras_rise >= 0)
                    chk(edges - t_ras_rise >= TP, "R6 precharge before cas", edges - t_ras_rise, TP);
            end
            if (p_ras && !ras_n) begin
                n_fall++;
                chk(cas_n == '0 && edges - t_cas_fall == TL, "R4 cas lead", edges - t_cas_fall, TL);
                chk(we_n == 1'b1, "R5 write enable high", we_n, 1);
                if (t_ras_rise >= 0)
                    chk(edges - t_ras_rise >= TP + TL, "R6 ras precharge", edges - t_ras_rise, TP + TL);
                if (space_on && last_fall_rdy)
                    chk(edges - t_ras_fall == IVL, "R3 refresh spacing", edges - t_ras_fall, IVL);
                t_ras_fall = edges;
                last_fall_rdy = rdy;
            end
            if (!p_cas && cas_n[0])
                chk(edges - t_ras_fall == TC, "R4 cas hold", edges - t_ras_fall, TC);
            if (!p_ras && ras_n) begin
                chk(edges - t_ras_fall == TR, "R6 ras pulse", edges - t_ras_fall, TR);
                t_ras_rise = edges;
            end
            if (!p_rdy && rdy)
                chk(n_fall == INIT, "R2 warm-up count at ready", n_fall, INIT);
            if (p_rdy && !rdy)
                chk(1'b0, "R2 ready dropped", 0, 1);
            if (p_ro_ras && !ro_ras_n) begin
                chk(ro_cas_n == '1, "R7 cas high in row-only", ro_cas_n, 15);
                chk(ro_row == RW'(exp_row), "R7 row address", ro_row, exp_row);
                if (exp_row == ROWS - 1) wrapped = 1'b1;
                exp_row = (exp_row + 1) % ROWS;
            end
        end
        p_ras = ras_n; p_cas = cas_n[0]; p_req = req; p_rdy = rdy; p_ro_ras = ro_ras_n;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check_reset_state(input string tag);
        chk(!req && !own && !rdy && !ro_req && !ro_own, {tag, " R10 control low"},
            {req, own, rdy}, 0);
        chk(ras_n && cas_n == '1 && we_n && ro_ras_n && ro_cas_n == '1, {tag, " R10 strobes high"},
            {ras_n, cas_n}, 31);
        chk(row == '0 && ro_row == '0, {tag, " R10 row zero"}, ro_row, 0);
    endtask

    // ---------------- main ----------------
    initial begin
        longint f0;
        step(3);
        check_reset_state("start");
        rst = 1'b0;

        // pause and warm-up: R1, R2 checked by monitor
        while (!rdy) step(1);
        chk(req_seen, "R1 request seen", req_seen, 1);

        // R3: coverage window with grant held
        f0 = n_fall;
        space_on = 1'b1;
        step(ROWS * IVL + TL + 1);
        chk(n_fall - f0 == ROWS, "R3 rows per window", n_fall - f0, ROWS);
        space_on = 1'b0;
        chk(wrapped, "R7 row counter wrapped", wrapped, 1);

        // R8, R9: withheld grants walked from table
        for (int v = 0; v < NVEC; v++) begin
            f0 = n_fall;
            while (n_fall == f0) step(1);
            while (own) step(1);
            gnt = 1'b0;
            f0 = n_fall;
            step(VEC[v][0] * IVL);
            chk(n_fall == f0, "R8 no cycle without grant", n_fall - f0, 0);
            chk(req && !own, "R8 request held, bus not owned", {req, own}, 2);
            gnt = 1'b1;
            step(50);
            chk(n_fall - f0 == VEC[v][1], "R9 make-up burst", n_fall - f0, VEC[v][1]);
        end

        // R10: reset mid-operation
        rst = 1'b1;
        step(2);
        check_reset_state("mid-run");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule